// File: doc/BRIEF.md
# Adder-based integer comparator

This block orders two 64-bit integer operands and reports the outcome as a 4-bit condition field. It has no magnitude comparator of its own. It uses a single carry-chain adder that forms the inverse of operand A, plus operand B, plus one, which gives B minus A. The ordering is worked out from three things: the result sign bit at the chosen width, the carry out of that width, and the sign bits of both operands. Equality is found by a separate direct comparison of the operands, not from the adder result.

One strobe covers both signed and unsigned compares. A signed flag picks the interpretation, and a word flag limits the compare to the low 32 bits. In that case the carry out of bit 31 and bit 31 of each value are used. A summary-overflow bit arrives from outside and is appended unchanged. The result is registered, so it appears one cycle after the strobe and stays until the next strobe.

Top module: `int_cmp_unit`

## Requirements
- R1: While rst_ni is low, and after it, until the first strobe, valid_o is 0 and cond_o is 4'b0000.
- R2: valid_o equals valid_i delayed by exactly one clock cycle. cond_o is loaded only on a cycle with valid_i high and otherwise holds its value.
- R3: The EQ bit, cond_o[1], is set when the operands are equal over the selected width. That width is all 64 bits when word_i is 0 and the low 32 bits when word_i is 1.
- R4: With signed_i=0 and word_i=0, the LT bit cond_o[3] is set when opa_i is less than opb_i as unsigned 64-bit values.
- R5: With signed_i=1 and word_i=0, cond_o[3] is set when opa_i is less than opb_i as two's-complement 64-bit values.
- R6: With word_i=1, bits 63:32 of both operands have no effect on cond_o[3:1]. The compare uses the low 32 bits only, as unsigned (signed_i=0) or as two's complement with bit 31 as the sign (signed_i=1).
- R7: Whenever valid_o is 1, exactly one of LT (cond_o[3]), GT (cond_o[2]) and EQ (cond_o[1]) is set. GT is set when neither of the others is.
- R8: cond_o[0] is the value of so_i in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare strobe |
| opa_i | input | 64 | Operand A (left side of the compare) |
| opb_i | input | 64 | Operand B (right side of the compare) |
| signed_i | input | 1 | 1 = two's-complement compare, 0 = unsigned |
| word_i | input | 1 | 1 = compare the low 32 bits only, 0 = full 64 bits |
| so_i | input | 1 | Summary-overflow bit appended to the result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| cond_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
The ordering path and the equality path both act on every strobe. The interesting cases are those where the adder alone would be ambiguous. Equal operands give a result of zero with a carry out of one, so the bench drives equal pairs in all four width and sign modes and checks that EQ wins and LT stays clear. It also drives pairs whose upper halves differ while the low halves are equal or ordered, and checks that word mode ignores the upper bits on both paths at the same time. Every result is judged against a behavioural reference built from native signed and unsigned comparisons.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/cmp_adder.sv
// Computes ~a + b + 1 lane by lane, exposing the carry out of every lane.
module cmp_adder #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [LANES-1:0]  carry_o
);
  logic [LANES:0] chain;
  assign chain[0] = 1'b1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W:0] part;
    assign part = {1'b0, ~a_i[l*LANE_W +: LANE_W]}
                + {1'b0, b_i[l*LANE_W +: LANE_W]}
                + {{LANE_W{1'b0}}, chain[l]};
    assign sum_o[l*LANE_W +: LANE_W] = part[LANE_W-1:0];
    assign chain[l+1]                = part[LANE_W];
  end

  assign carry_o = chain[LANES:1];
endmodule

// File: rtl/cmp_equal.sv
// Direct operand equality, per lane, reduced over the selected width.
module cmp_equal #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              word_i,
  output logic              eq_o
);
  logic [LANES-1:0] lane_eq;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (a_i[l*LANE_W +: LANE_W] == b_i[l*LANE_W +: LANE_W]);
  end

  assign eq_o = word_i ? lane_eq[0] : &lane_eq;
endmodule

// File: rtl/cmp_order.sv
// Derives LT/GT from the difference b - a at the selected width.
module cmp_order (
  input  logic signed_i,
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic diff_msb_i,
  input  logic carry_i,
  input  logic eq_i,
  output logic lt_o,
  output logic gt_o
);
  logic lt_uns, lt_sgn;

  // no borrow out of b - a means b >= a
  assign lt_uns = carry_i & ~eq_i;
  // differing signs: the negative one is smaller; otherwise no overflow is possible
  assign lt_sgn = (a_msb_i ^ b_msb_i) ? a_msb_i : (~diff_msb_i & ~eq_i);

  assign lt_o = signed_i ? lt_sgn : lt_uns;
  assign gt_o = ~lt_o & ~eq_i;

  always_comb begin
    if (eq_i) assert_eq_excl_r7 : assert (!lt_o && !gt_o);
  end
endmodule

// File: rtl/int_cmp_unit.sv
module int_cmp_unit
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              signed_i,
  input  logic              word_i,
  input  logic              so_i,
  output logic              valid_o,
  output logic [3:0]        cond_o
);
  localparam int unsigned HI_LANE = LANES - 1;

  logic [DATA_W-1:0] diff;
  logic [LANES-1:0]  carry;
  logic              eq, lt, gt;
  logic              sel_carry, sel_dmsb, sel_amsb, sel_bmsb;
  cond_t             cond_d, cond_q;

  cmp_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_adder (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sum_o  (diff),
    .carry_o(carry)
  );

  cmp_equal #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_equal (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .word_i(word_i),
    .eq_o  (eq)
  );

  // word mode looks at lane 0, full mode at the top lane
  always_comb begin
    if (word_i) begin
      sel_carry = carry[0];
      sel_dmsb  = diff[LANE_W-1];
      sel_amsb  = opa_i[LANE_W-1];
      sel_bmsb  = opb_i[LANE_W-1];
    end else begin
      sel_carry = carry[HI_LANE];
      sel_dmsb  = diff[DATA_W-1];
      sel_amsb  = opa_i[DATA_W-1];
      sel_bmsb  = opb_i[DATA_W-1];
    end
  end

  cmp_order i_order (
    .signed_i  (signed_i),
    .a_msb_i   (sel_amsb),
    .b_msb_i   (sel_bmsb),
    .diff_msb_i(sel_dmsb),
    .carry_i   (sel_carry),
    .eq_i      (eq),
    .lt_o      (lt),
    .gt_o      (gt)
  );

  assign cond_d = '{lt: lt, gt: gt, eq: eq, so: so_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cond_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) cond_q <= cond_d;
    end
  end

  assign cond_o = cond_q;

  assert_valid_lat_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_lat_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(cond_o)));
  assert_one_hot_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(cond_o[3:1]) == 1));
  assert_so_copy_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cond_o[0] == $past(so_i)));
  assert_eq_full_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (opa_i == opb_i)) |=> cond_o[1]);
  assert_eq_word_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i && (opa_i[LANE_W-1:0] != opb_i[LANE_W-1:0])) |=> !cond_o[1]);
endmodule

// File: tb/test_int_cmp_unit.sv
module test_int_cmp_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        signed_i = 1'b0, word_i = 1'b0, so_i = 1'b0;
  logic        valid_o;
  logic [3:0]  cond_o;

  int n_checks = 0;
  int n_fails  = 0;

  int_cmp_unit i_int_cmp_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .opa_i(opa_i), .opb_i(opb_i), .signed_i(signed_i),
    .word_i(word_i), .so_i(so_i), .valid_o(valid_o), .cond_o(cond_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [3:0] ref_cond(logic [63:0] a, logic [63:0] b,
                                          logic sg, logic wd, logic so);
    logic lt, eq;
    if (wd) begin
      eq = (a[31:0] == b[31:0]);
      lt = sg ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
    end else begin
      eq = (a == b);
      lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    end
    return {lt, !lt && !eq, eq, so};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic do_cmp(string req, logic [63:0] a, logic [63:0] b,
                        logic sg, logic wd, logic so);
    @(negedge clk_i);
    opa_i = a; opb_i = b; signed_i = sg; word_i = wd; so_i = so; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, {63'd0, valid_o}, 64'd1);
    check(req, {60'd0, cond_o}, {60'd0, ref_cond(a, b, sg, wd, so)});
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    check("R1 valid in reset", {63'd0, valid_o}, 64'd0);
    check("R1 cond in reset", {60'd0, cond_o}, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 cond after reset", {60'd0, cond_o}, 64'd0);
  endtask

  task automatic t_corners;
    logic [63:0] v [6];
    v[0] = 64'h0; v[1] = 64'h8000_0000_0000_0000; v[2] = 64'h7FFF_FFFF_FFFF_FFFF;
    v[3] = 64'hFFFF_FFFF_FFFF_FFFF; v[4] = 64'h0000_0000_8000_0000; v[5] = 64'h0000_0000_7FFF_FFFF;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          do_cmp(m[1] ? "R6 corner word" : (m[0] ? "R5 corner signed" : "R4 corner unsigned"),
                 v[i], v[j], m[0], m[1], 1'b0);
  endtask

  task automatic t_equal;
    for (int m = 0; m < 4; m++) begin
      logic [63:0] x = {$urandom(), $urandom()};
      do_cmp("R3 equal R7", x, x, m[0], m[1], 1'b0);
    end
  endtask

  task automatic t_upper_ignored;
    do_cmp("R3 word upper differ eq", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 1'b0, 1'b1, 1'b0);
    check("R3 eq bit", {63'd0, cond_o[1]}, 64'd1);
    do_cmp("R6 word upper ignored lt", 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_0000_0009, 1'b0, 1'b1, 1'b0);
    check("R6 lt bit", {63'd0, cond_o[3]}, 64'd1);
    do_cmp("R6 word signed bit31", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b1, 1'b1, 1'b0);
    check("R6 signed lt bit", {63'd0, cond_o[3]}, 64'd1);
  endtask

  task automatic t_so;
    do_cmp("R8 so set", 64'd1, 64'd2, 1'b0, 1'b0, 1'b1);
    check("R8 so bit", {63'd0, cond_o[0]}, 64'd1);
    do_cmp("R8 so clear", 64'd1, 64'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    do_cmp("R2 load", 64'd7, 64'd3, 1'b0, 1'b0, 1'b1);
    @(negedge clk_i);
    opa_i = 64'd1; opb_i = 64'd9; so_i = 1'b0; valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 no strobe valid", {63'd0, valid_o}, 64'd0);
    check("R2 no strobe hold", {60'd0, cond_o}, {60'd0, 4'b0101});
  endtask

  task automatic t_random;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 300; k++) begin
        logic [63:0] a = {$urandom(), $urandom()};
        logic [63:0] b = (k % 7 == 0) ? a : {$urandom(), $urandom()};
        if (k % 5 == 0) b[31:0] = a[31:0];
        do_cmp(m[1] ? "R6 random word R7" : (m[0] ? "R5 random signed R7" : "R4 random unsigned R7"),
               a, b, m[0], m[1], k[0]);
      end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_equal();
    t_upper_ignored();
    t_so();
    t_hold();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule